// File: doc/BRIEF.md
# Exception-Return Status Shifter

This block computes the status-word update a processor core performs when it leaves an exception or NMI handler. The status word holds a stack of flag levels. Each level is ten bits wide, and older levels sit in higher bit groups. A return pops one level: the field below the two protected top bits moves down by one level, and the freed upper part is cleared. The privilege flag of the restored level then decides whether the stack pointer is exchanged. If it is, the live SP is saved as the kernel SP and the saved user SP becomes the live SP.

Two more flags are fixed up after the pop. The pending-return flag P is set when the retry flag R in the old word was clear. An NMI return also sets the mode flag M, while an exception return leaves M alone. The core pulses `ret_valid` for one cycle, with `ret_is_nmi` selecting the variant. One clock later the block presents the new status and stack pointers and pulses `done`.

Top module: `exc_return_shifter`

## Requirements
- R1: Bit 31 of `status_out` equals bit 31 of the `status_in` that was presented with the strobe.
- R2: `status_out[17:0]` equals `status_in[27:10]`, except that bit 7 may also be forced to 1 (R5). Bits [29:18] of `status_out` are zero, which drops input bits [29:28].
- R3: When the restored user flag is set, the block swaps the stack pointers. The user flag is bit 6 after the shift, which is input bit 16. On a swap, `sp_out` takes `usp_in`, `ksp_out` takes `sp_in`, and `sp_swap` is 1.
- R4: When the restored user flag is clear, `sp_out` takes `sp_in`, `ksp_out` keeps its previous value, and `sp_swap` is 0.
- R5: Bit 7 of `status_out` is set to 1 when bit 8 of `status_in` is 0. Otherwise bit 7 is the shifted value, which is input bit 17.
- R6: On an NMI return (`ret_is_nmi`=1), bit 30 of `status_out` is 1.
- R7: On an exception return (`ret_is_nmi`=0), bit 30 of `status_out` equals bit 30 of `status_in`.
- R8: All outputs update on the first rising edge after a cycle with `ret_valid`=1, and `done` is high for exactly that one cycle. Otherwise every output holds its value, and `done` and `sp_swap` are 0. Back-to-back strobes each produce their own result.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | One-cycle return strobe |
| ret_is_nmi | input | 1 | 1 = NMI return, 0 = exception return |
| status_in | input | 32 | Status word before the return |
| sp_in | input | 32 | Live stack pointer |
| usp_in | input | 32 | Saved user stack pointer |
| status_out | output | 32 | Status word after the return |
| sp_out | output | 32 | Stack pointer after the return |
| ksp_out | output | 32 | Saved kernel stack pointer |
| sp_swap | output | 1 | Pulses with `done` when the pointers were exchanged |
| done | output | 1 | Result-valid pulse, one cycle after the strobe |

## Verification
Every cycle, the assertions check the one-cycle strobe-to-done timing. They also check the protected top bit, the zeroed gap, the P and M flag rules, and both stack-pointer outcomes against the inputs sampled with the strobe. The bench scenarios show what single-cycle properties cannot: that the whole low field carries the exact shifted bits, that outputs stay unchanged across idle cycles with garbage inputs, that back-to-back returns chain the kernel SP correctly, and that reset clears the state.

// File: rtl/exc_ret_pkg.sv
package exc_ret_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LEVEL_W   = 10;
  localparam int unsigned KEEP_W    = 2;
  localparam int unsigned GAP_W     = 2;
  localparam int unsigned USER_BIT  = 6;
  localparam int unsigned PEND_BIT  = 7;
  localparam int unsigned RETRY_BIT = 8;
  localparam int unsigned MODE_BIT  = 30;

  typedef enum logic {RET_EXC = 1'b0, RET_NMI = 1'b1} ret_kind_e;
endpackage

// File: rtl/ers_stack_shift.sv
module ers_stack_shift #(
  parameter int unsigned W      = 32,
  parameter int unsigned LVL    = 10,
  parameter int unsigned KEEP   = 2,
  parameter int unsigned GAP    = 2,
  parameter int unsigned U_POS  = 6
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o,
  output logic         user_o
);
  localparam int unsigned FIELD_W = W - KEEP - GAP;
  localparam int unsigned MOVED_W = FIELD_W - LVL;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= W - KEEP) begin : g_keep
      assign word_o[i] = word_i[i];
    end else if (i < MOVED_W) begin : g_move
      assign word_o[i] = word_i[i + LVL];
    end else begin : g_clear
      assign word_o[i] = 1'b0;
    end
  end

  assign user_o = word_o[U_POS];
endmodule

// File: rtl/ers_flag_fix.sv
module ers_flag_fix #(
  parameter int unsigned W     = 32,
  parameter int unsigned P_POS = 7,
  parameter int unsigned M_POS = 30
) (
  input  logic [W-1:0]          shifted_i,
  input  logic                  retry_pre_i,
  input  exc_ret_pkg::ret_kind_e kind_i,
  output logic [W-1:0]          fixed_o
);
  function automatic logic [W-1:0] fix_flags(input logic [W-1:0] s,
                                             input logic retry,
                                             input logic nmi);
    logic [W-1:0] r;
    r = s;
    if (!retry) r[P_POS] = 1'b1;
    if (nmi)    r[M_POS] = 1'b1;
    return r;
  endfunction

  assign fixed_o = fix_flags(shifted_i, retry_pre_i, kind_i == exc_ret_pkg::RET_NMI);
endmodule

// File: rtl/ers_sp_swap.sv
module ers_sp_swap #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         user_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] usp_i,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] ksp_o,
  output logic         swap_o
);
  logic swap_now;
  assign swap_now = load_i && user_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_o   <= '0;
      ksp_o  <= '0;
      swap_o <= 1'b0;
    end else begin
      swap_o <= swap_now;
      if (load_i) sp_o <= user_i ? usp_i : sp_i;
      if (swap_now) ksp_o <= sp_i;
    end
  end

  p_swap_ptrs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && user_i) |=> (sp_o == $past(usp_i)) && (ksp_o == $past(sp_i)) && swap_o);

  p_keep_ksp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !user_i) |=> $stable(ksp_o) && (sp_o == $past(sp_i)) && !swap_o);
endmodule

// File: rtl/exc_return_shifter.sv
module exc_return_shifter #(
  parameter int unsigned DATA_W    = exc_ret_pkg::DATA_W,
  parameter int unsigned LEVEL_W   = exc_ret_pkg::LEVEL_W,
  parameter int unsigned KEEP_W    = exc_ret_pkg::KEEP_W,
  parameter int unsigned GAP_W     = exc_ret_pkg::GAP_W,
  parameter int unsigned USER_BIT  = exc_ret_pkg::USER_BIT,
  parameter int unsigned PEND_BIT  = exc_ret_pkg::PEND_BIT,
  parameter int unsigned RETRY_BIT = exc_ret_pkg::RETRY_BIT,
  parameter int unsigned MODE_BIT  = exc_ret_pkg::MODE_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic              ret_is_nmi,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] usp_in,
  output logic [DATA_W-1:0] status_out,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] ksp_out,
  output logic              sp_swap,
  output logic              done
);
  localparam int unsigned GAP_LO = DATA_W - KEEP_W - GAP_W - LEVEL_W;
  localparam int unsigned GAP_HI = DATA_W - KEEP_W - 1;

  logic [DATA_W-1:0]      shifted_w;
  logic [DATA_W-1:0]      fixed_w;
  logic                   retry_pre_w;
  logic                   user_post_w;
  exc_ret_pkg::ret_kind_e kind_w;
  logic [DATA_W-1:0]      status_q;
  logic                   done_q;

  assign retry_pre_w = status_in[RETRY_BIT];
  assign kind_w      = ret_is_nmi ? exc_ret_pkg::RET_NMI : exc_ret_pkg::RET_EXC;

  ers_stack_shift #(
    .W(DATA_W), .LVL(LEVEL_W), .KEEP(KEEP_W), .GAP(GAP_W), .U_POS(USER_BIT)
  ) u_shift (
    .word_i (status_in),
    .word_o (shifted_w),
    .user_o (user_post_w)
  );

  ers_flag_fix #(
    .W(DATA_W), .P_POS(PEND_BIT), .M_POS(MODE_BIT)
  ) u_fix (
    .shifted_i   (shifted_w),
    .retry_pre_i (retry_pre_w),
    .kind_i      (kind_w),
    .fixed_o     (fixed_w)
  );

  ers_sp_swap #(.W(DATA_W)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ret_valid),
    .user_i (user_post_w),
    .sp_i   (sp_in),
    .usp_i  (usp_in),
    .sp_o   (sp_out),
    .ksp_o  (ksp_out),
    .swap_o (sp_swap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= ret_valid;
      if (ret_valid) status_q <= fixed_w;
    end
  end

  assign status_out = status_q;
  assign done       = done_q;

  // R8: one result pulse per strobe, none otherwise
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> !done && !sp_swap && $stable(status_out));

  p_top_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> status_out[DATA_W-1] == $past(status_in[DATA_W-1]));

  p_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> status_out[GAP_HI:GAP_LO] == '0);

  p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !status_in[RETRY_BIT]) |=> status_out[PEND_BIT]);

  p_mode_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_is_nmi) |=> status_out[MODE_BIT]);

  p_mode_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_is_nmi) |=> status_out[MODE_BIT] == $past(status_in[MODE_BIT]));
endmodule

// File: tb/exc_return_shifter_test.sv
`timescale 1ns/1ps
module exc_return_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic        ret_is_nmi = 1'b0;
  logic [31:0] status_in = '0;
  logic [31:0] sp_in = '0;
  logic [31:0] usp_in = '0;
  logic [31:0] status_out, sp_out, ksp_out;
  logic        sp_swap, done;

  int errors = 0;
  int checks = 0;
  logic [31:0] ksp_model = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  exc_return_shifter uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_is_nmi(ret_is_nmi),
    .status_in(status_in), .sp_in(sp_in), .usp_in(usp_in),
    .status_out(status_out), .sp_out(sp_out), .ksp_out(ksp_out),
    .sp_swap(sp_swap), .done(done)
  );

  // {nmi, status, sp, usp}
  localparam logic [96:0] VEC [8] = '{
    {1'b0, 32'h0000_0000, 32'h0000_1000, 32'h0000_2000},
    {1'b0, 32'h0001_0100, 32'h0000_1100, 32'h0000_2100},
    {1'b1, 32'hC000_0000, 32'h0000_1200, 32'h0000_2200},
    {1'b1, 32'h0FFF_FFFF, 32'h0000_1300, 32'h0000_2300},
    {1'b0, 32'hFFFF_FFFF, 32'h0000_1400, 32'h0000_2400},
    {1'b0, 32'h4002_0000, 32'h0000_1500, 32'h0000_2500},
    {1'b1, 32'h8001_0100, 32'h0000_1600, 32'h0000_2600},
    {1'b0, 32'h3000_0100, 32'h0000_1700, 32'h0000_2700}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-by-bit restatement of R1, R2, R5, R6, R7
  function automatic logic [31:0] model_status(input logic nmi, input logic [31:0] s);
    logic [31:0] e;
    for (int i = 0; i < 32; i++) begin
      if (i >= 30)      e[i] = s[i];
      else if (i < 18)  e[i] = s[i + 10];
      else              e[i] = 1'b0;
    end
    if (s[8] == 1'b0) e[7] = 1'b1;
    if (nmi) e[30] = 1'b1;
    return e;
  endfunction

  task automatic drive(input logic nmi, input logic [31:0] s, input logic [31:0] sp,
                       input logic [31:0] usp);
    ret_valid = 1'b1; ret_is_nmi = nmi; status_in = s; sp_in = sp; usp_in = usp;
  endtask

  task automatic expect_result(input logic nmi, input logic [31:0] s, input logic [31:0] sp,
                               input logic [31:0] usp);
    logic user;
    user = s[16];
    check("R8 done", {31'd0, done}, 32'd1);
    check("R1/R2/R5/R6/R7 status", status_out, model_status(nmi, s));
    if (user) begin
      ksp_model = sp;
      check("R3 sp", sp_out, usp);
      check("R3 ksp", ksp_out, ksp_model);
      check("R3 swap", {31'd0, sp_swap}, 32'd1);
    end else begin
      check("R4 sp", sp_out, sp);
      check("R4 ksp", ksp_out, ksp_model);
      check("R4 swap", {31'd0, sp_swap}, 32'd0);
    end
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 status", status_out, 32'd0);
    check("R9 sp", sp_out, 32'd0);
    check("R9 ksp", ksp_out, 32'd0);
    check("R9 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      drive(VEC[v][96], VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);
      @(negedge clk);
      ret_valid = 1'b0;
      expect_result(VEC[v][96], VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);
    end

    // R8: idle cycles with garbage inputs leave outputs unchanged
    held = status_out;
    status_in = 32'hA5A5_5A5A; sp_in = 32'hDEAD_0000; usp_in = 32'hBEEF_0000; ret_is_nmi = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 idle done", {31'd0, done}, 32'd0);
      check("R8 idle status", status_out, held);
      check("R8 idle ksp", ksp_out, ksp_model);
    end

    // R8/R3/R4: back-to-back strobes, swap then no swap
    drive(1'b0, 32'h0001_0000, 32'h0000_3000, 32'h0000_4000);
    @(negedge clk);
    expect_result(1'b0, 32'h0001_0000, 32'h0000_3000, 32'h0000_4000);
    drive(1'b1, 32'h0000_0100, 32'h0000_5000, 32'h0000_6000);
    @(negedge clk);
    ret_valid = 1'b0;
    expect_result(1'b1, 32'h0000_0100, 32'h0000_5000, 32'h0000_6000);
    check("R4 ksp kept from prior swap", ksp_out, 32'h0000_3000);

    // R7: exception return keeps bit 30 clear; R5: R set keeps shifted P
    drive(1'b0, 32'h0002_0100, 32'h0000_7000, 32'h0000_8000);
    @(negedge clk);
    ret_valid = 1'b0;
    check("R7 mode kept clear", {31'd0, status_out[30]}, 32'd0);
    check("R5 pend from shift", {31'd0, status_out[7]}, 32'd1);

    // R9: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 status after rerst", status_out, 32'd0);
    check("R9 ksp after rerst", ksp_out, 32'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule